// File: doc/BRIEF.md
# Multiprocessor Serial Line Transmitter

This block sends characters on one asynchronous serial line. Software writes a byte into a one-entry holding buffer. On the next bit-rate tick the block turns that byte into a complete frame and shifts it out. Every later tick advances the line by one bit. The frame layout comes from a set of format inputs:

- parity off, odd or even;
- least or most significant bit first;
- seven or eight data bits;
- one or two stop bits;
- one of four line modes.

Two of the line modes serve shared buses with several receivers. In address-bit mode every frame carries an extra marker bit after the data. In idle-line mode an address frame is preceded by a long quiet gap on the line. Two one-shot requests attach to the next byte taken from the buffer: an address marking and a break. A break is a frame-long low period with no character in it. A level-sensitive software reset holds all of the logic idle. Changes to the format inputs take effect only while that reset is high.

Top module: `mpu_uart_tx`

## Requirements
- R1: Hardware reset (`rst`) and software reset (`soft_rst`) both leave `txd`=1, `busy`=0, `buf_empty`=1, `addr_flag`=0 and `brk_flag`=0. Raising `soft_rst` in the middle of a frame returns the block to that state one cycle later. While `soft_rst`=1, the inputs `wr_en`, `set_addr` and `set_brk` have no effect.
- R2: The format inputs are captured only in cycles where `rst` or `soft_rst` is 1. Changing them while `soft_rst`=0 does not alter the frames that follow.
- R3: A frame starts on the first `baud_tick` that sees a full buffer. Each bit stays on `txd` from one tick to the next. The start bit is 0. Next come the data bits: 8 bits when `cfg_len7`=0, or bits 6..0 when `cfg_len7`=1. They go out least significant first when `cfg_msb_first`=0 and most significant first when it is 1.
- R4: When `cfg_par_en`=1, a parity bit follows the data and any address bit. With `cfg_par_even`=1 the count of ones over the data, the address bit and the parity bit is even; with `cfg_par_even`=0 it is odd. When `cfg_par_en`=0 there is no parity bit and `cfg_par_even` has no effect.
- R5: The frame ends with one high stop bit when `cfg_two_stop`=0 and with two when it is 1.
- R6: With `cfg_mode`=2'b10, one extra bit follows the data: 1 in an address frame, 0 in a data frame. Modes 2'b00 and 2'b11 add no extra bit.
- R7: With `cfg_mode`=2'b01, an address frame begins with 11 bit times of high line while `busy`=1, and only then sends its start bit. Data frames in this mode begin with the start bit at once.
- R8: A pulse on `set_addr` sets `addr_flag`. The next frame taken from the buffer becomes an address frame, and taking it clears the flag. If the pulse arrives in the same cycle as that take, the flag stays set and applies to the following frame.
- R9: A pulse on `set_brk` sets `brk_flag`. The next frame taken ignores its data byte and holds `txd` low for L bit times, then high for one bit time. L is the length of a normal data frame in the current format (start, data, address bit, parity, stops). Taking the frame clears `brk_flag`, and a break never gets the idle prefix.
- R10: `buf_empty` falls in the cycle after a write and rises in the cycle after the byte moves into the shift register. A write in the same cycle as that move keeps `buf_empty` at 0. The new byte's frame then follows the current one with no idle bit in between.
- R11: `busy` is 1 from the tick that takes a frame until the tick that ends its last bit. Whenever `busy` is 0, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software hold-in-reset level; format captured while high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_msb_first | input | 1 | 1 most significant data bit first |
| cfg_len7 | input | 1 | 1 seven data bits, 0 eight |
| cfg_two_stop | input | 1 | 1 two stop bits, 0 one |
| cfg_mode | input | 2 | 00 plain, 01 idle-line, 10 address-bit, 11 plain |
| set_addr | input | 1 | Mark next frame as an address frame |
| set_brk | input | 1 | Make next frame a break |
| wr_en | input | 1 | Write `wr_data` into the holding buffer |
| wr_data | input | 8 | Byte to send |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| buf_empty | output | 1 | Holding buffer free |
| addr_flag | output | 1 | Address marking pending |
| brk_flag | output | 1 | Break pending |

## Verification
Two pairs of actions can fall in the same clock cycle. The first is a buffer write landing on the tick that moves the previous byte into the shift register. The bench provokes it by raising `wr_en` and `baud_tick` together. It judges the outcome from `buf_empty` staying low and from the second frame's start bit directly following the first frame's last stop bit. The second pair is a `set_addr` pulse landing on the tick that takes a frame. The bench judges it from the marker bit of that frame, which must be 0, from `addr_flag` staying high, and from the marker bit of the next frame, which must be 1. Every format combination is swept with and without an address marking, and again as a break. Each expected bit string is built by counting in the bench.

// File: rtl/mputx_pkg.sv
package mputx_pkg;
  localparam int CHAR_W   = 8;
  localparam int MAX_STOP = 2;

  typedef enum logic [1:0] {
    MD_PLAIN = 2'b00,
    MD_IDLE  = 2'b01,
    MD_ADDR  = 2'b10,
    MD_AUTO  = 2'b11
  } mode_e;

  typedef struct packed {
    logic  par_en;
    logic  par_even;
    logic  msb_first;
    logic  len7;
    logic  two_stop;
    mode_e mode;
  } fmt_t;
endpackage

// File: rtl/mputx_framer.sv
module mputx_framer
  import mputx_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  parameter int FRAME_W   = 24,
  parameter int LEN_W     = 5
) (
  input  fmt_t               fmt,
  input  logic [CHAR_W-1:0]  data,
  input  logic               mark_addr,
  input  logic               mark_brk,
  output logic [FRAME_W-1:0] bits,
  output logic [LEN_W-1:0]   nbits
);
  always_comb begin
    int   pos;
    int   nd;
    logic par;
    logic b;
    bits = '1;
    pos  = 0;
    par  = 1'b0;
    b    = 1'b0;
    nd   = fmt.len7 ? CHAR_W - 1 : CHAR_W;
    // quiet gap ahead of an address frame in idle-line mode
    if (fmt.mode == MD_IDLE && mark_addr && !mark_brk) pos = IDLE_BITS;
    bits[pos] = 1'b0;
    pos = pos + 1;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < nd) begin
        b = fmt.msb_first ? data[nd-1-i] : data[i];
        bits[pos] = b;
        par = par ^ b;
        pos = pos + 1;
      end
    end
    if (fmt.mode == MD_ADDR) begin
      bits[pos] = mark_addr;
      par = par ^ mark_addr;
      pos = pos + 1;
    end
    if (fmt.par_en) begin
      bits[pos] = fmt.par_even ? par : ~par;
      pos = pos + 1;
    end
    pos = pos + (fmt.two_stop ? MAX_STOP : 1);
    if (mark_brk) begin
      for (int j = 0; j < FRAME_W; j++) begin
        if (j < pos) bits[j] = 1'b0;
      end
      pos = pos + 1;
    end
    nbits = LEN_W'(pos);
  end
endmodule

// File: rtl/mputx_hold.sv
module mputx_hold
  import mputx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  fmt_t              fmt_in,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              set_addr,
  input  logic              set_brk,
  input  logic              take,
  output fmt_t              fmt_q,
  output logic [CHAR_W-1:0] buf_data,
  output logic              buf_full,
  output logic              addr_flag,
  output logic              brk_flag
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      fmt_q     <= fmt_in;
      buf_data  <= '0;
      buf_full  <= 1'b0;
      addr_flag <= 1'b0;
      brk_flag  <= 1'b0;
    end else begin
      if (wr_en) begin
        buf_data <= wr_data;
        buf_full <= 1'b1;
      end else if (take) begin
        buf_full <= 1'b0;
      end
      addr_flag <= set_addr | (addr_flag & ~take);
      brk_flag  <= set_brk  | (brk_flag  & ~take);
    end
  end
endmodule

// File: rtl/mputx_shift.sv
module mputx_shift #(
  parameter int FRAME_W = 24,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic               baud_tick,
  input  logic               buf_full,
  input  logic [FRAME_W-1:0] bits,
  input  logic [LEN_W-1:0]   nbits,
  output logic               take,
  output logic               txd,
  output logic               busy
);
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   remain;
  logic               more;

  assign more = busy && (remain != '0);
  assign take = baud_tick && buf_full && !more && !rst && !soft_rst;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      shreg  <= '1;
      remain <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
    end else if (baud_tick) begin
      if (more) begin
        txd    <= shreg[0];
        shreg  <= {1'b1, shreg[FRAME_W-1:1]};
        remain <= remain - 1'b1;
      end else if (buf_full) begin
        txd    <= bits[0];
        shreg  <= {1'b1, bits[FRAME_W-1:1]};
        remain <= nbits - 1'b1;
        busy   <= 1'b1;
      end else begin
        txd  <= 1'b1;
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpu_uart_tx.sv
module mpu_uart_tx
  import mputx_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  localparam int FRAME_W  = IDLE_BITS + 1 + CHAR_W + 2 + MAX_STOP,
  localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_msb_first,
  input  logic              cfg_len7,
  input  logic              cfg_two_stop,
  input  logic [1:0]        cfg_mode,
  input  logic              set_addr,
  input  logic              set_brk,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              baud_tick,
  output logic              txd,
  output logic              busy,
  output logic              buf_empty,
  output logic              addr_flag,
  output logic              brk_flag
);
  fmt_t               fmt_in;
  fmt_t               fmt_q;
  logic [CHAR_W-1:0]  buf_data;
  logic               buf_full;
  logic               take;
  logic [FRAME_W-1:0] frame_bits;
  logic [LEN_W-1:0]   frame_len;

  assign fmt_in = '{par_en:    cfg_par_en,
                    par_even:  cfg_par_even,
                    msb_first: cfg_msb_first,
                    len7:      cfg_len7,
                    two_stop:  cfg_two_stop,
                    mode:      mode_e'(cfg_mode)};

  mputx_hold u_hold (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .fmt_in    (fmt_in),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .set_addr  (set_addr),
    .set_brk   (set_brk),
    .take      (take),
    .fmt_q     (fmt_q),
    .buf_data  (buf_data),
    .buf_full  (buf_full),
    .addr_flag (addr_flag),
    .brk_flag  (brk_flag)
  );

  mputx_framer #(.IDLE_BITS(IDLE_BITS), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .fmt       (fmt_q),
    .data      (buf_data),
    .mark_addr (addr_flag),
    .mark_brk  (brk_flag),
    .bits      (frame_bits),
    .nbits     (frame_len)
  );

  mputx_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .baud_tick (baud_tick),
    .buf_full  (buf_full),
    .bits      (frame_bits),
    .nbits     (frame_len),
    .take      (take),
    .txd       (txd),
    .busy      (busy)
  );

  assign buf_empty = ~buf_full;
endmodule

// File: rtl/mpu_uart_tx_chk.sv
module mpu_uart_tx_chk #(
  parameter int FMT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic             wr_en,
  input logic             baud_tick,
  input logic             txd,
  input logic             busy,
  input logic             buf_empty,
  input logic             addr_flag,
  input logic             brk_flag,
  input logic [FMT_W-1:0] fmt_bits
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);                                                  // R11
  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!busy && txd && buf_empty && !addr_flag && !brk_flag)); // R1
  AST_FORMAT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> $stable(fmt_bits));                                // R2
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst) |=> !buf_empty);                            // R10
  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(baud_tick));                               // R3
  AST_ADDR_CLEAR_AT_TAKE: assert property (@(posedge clk) disable iff (rst)
    ($fell(addr_flag) && !$past(soft_rst)) |-> busy);                // R8
endmodule

bind mpu_uart_tx mpu_uart_tx_chk #(.FMT_W($bits(mputx_pkg::fmt_t))) u_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_rst  (soft_rst),
  .wr_en     (wr_en),
  .baud_tick (baud_tick),
  .txd       (txd),
  .busy      (busy),
  .buf_empty (buf_empty),
  .addr_flag (addr_flag),
  .brk_flag  (brk_flag),
  .fmt_bits  (fmt_q)
);

// File: tb/mpu_uart_tx_tb.sv
module mpu_uart_tx_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_msb_first = 1'b0;
  logic       cfg_len7 = 1'b0, cfg_two_stop = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       set_addr = 1'b0, set_brk = 1'b0, wr_en = 1'b0, baud_tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, busy, buf_empty, addr_flag, brk_flag;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mpu_uart_tx u_dut (
    .clk (clk), .rst (rst), .soft_rst (soft_rst),
    .cfg_par_en (cfg_par_en), .cfg_par_even (cfg_par_even),
    .cfg_msb_first (cfg_msb_first), .cfg_len7 (cfg_len7),
    .cfg_two_stop (cfg_two_stop), .cfg_mode (cfg_mode),
    .set_addr (set_addr), .set_brk (set_brk), .wr_en (wr_en),
    .wr_data (wr_data), .baud_tick (baud_tick), .txd (txd), .busy (busy),
    .buf_empty (buf_empty), .addr_flag (addr_flag), .brk_flag (brk_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  // cf bits: [1:0] mode, [2] two stop, [3] 7-bit, [4] msb first, [5] even, [6] parity on
  task automatic apply_cfg(input int cf);
    @(negedge clk);
    soft_rst      = 1'b1;
    cfg_mode      = cf[1:0];
    cfg_two_stop  = cf[2];
    cfg_len7      = cf[3];
    cfg_msb_first = cf[4];
    cfg_par_even  = cf[5];
    cfg_par_en    = cf[6];
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic pulse_addr();
    @(negedge clk); set_addr = 1'b1;
    @(negedge clk); set_addr = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); set_brk = 1'b1;
    @(negedge clk); set_brk = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
  endtask

  // Expected line bits, index 0 first on the wire.
  function automatic void expect_frame(input int cf, input logic [7:0] d,
                                       input bit adr, input bit brk,
                                       output logic [31:0] e, output int n);
    int nd;
    int ones;
    bit b;
    e = '1;
    n = 0;
    ones = 0;
    nd = cf[3] ? 7 : 8;
    if (cf[1:0] == 2'b01 && adr && !brk) n = 11;
    e[n] = 1'b0; n++;
    for (int k = 0; k < nd; k++) begin
      b = cf[4] ? d[nd-1-k] : d[k];
      e[n] = b;
      ones += int'(b);
      n++;
    end
    if (cf[1:0] == 2'b10) begin
      e[n] = adr;
      ones += int'(adr);
      n++;
    end
    if (cf[6]) begin
      e[n] = cf[5] ? ((ones % 2) == 1) : ((ones % 2) == 0);
      n++;
    end
    n += cf[2] ? 2 : 1;
    if (brk) begin
      for (int k = 0; k < n; k++) e[k] = 1'b0;
      n++;
    end
  endfunction

  function automatic string pick_tag(input int cf, input bit adr, input bit brk);
    if (brk) return "R9";
    if (cf[1:0] == 2'b01 && adr) return "R7";
    if (cf[1:0] == 2'b10) return "R6";
    if (cf[6]) return "R4";
    if (cf[2]) return "R5";
    return "R3";
  endfunction

  task automatic send_bits(input logic [31:0] e, input int n, input int from,
                           input string req);
    logic [31:0] got;
    bit ok;
    got = e;
    ok = 1'b1;
    for (int k = from; k < n; k++) begin
      tick();
      got[k] = txd;
      if (txd !== e[k] || busy !== 1'b1) ok = 1'b0;
    end
    check(ok, req, "frame bits", got, e);
  endtask

  task automatic idle_check(input string req);
    tick();
    check(txd === 1'b1 && busy === 1'b0, req, "idle after frame",
          {30'd0, txd, busy}, 32'h2);
  endtask

  task automatic run_one(input int cf, input logic [7:0] d, input bit adr, input bit brk);
    logic [31:0] e;
    int n;
    apply_cfg(cf);
    if (adr) pulse_addr();
    if (brk) pulse_brk();
    write_byte(d);
    check(buf_empty === 1'b0, "R10", "buffer full after write", {31'd0, buf_empty}, 32'h0);
    expect_frame(cf, d, adr, brk, e, n);
    send_bits(e, n, 0, pick_tag(cf, adr, brk));
    idle_check("R11");
    check(buf_empty === 1'b1 && addr_flag === 1'b0 && brk_flag === 1'b0, "R8",
          "flags cleared and buffer empty after frame",
          {29'd0, buf_empty, addr_flag, brk_flag}, 32'h4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ea, eb;
    int na, nb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1 && busy === 1'b0 && buf_empty === 1'b1 && addr_flag === 1'b0 &&
          brk_flag === 1'b0, "R1", "reset state",
          {27'd0, txd, busy, buf_empty, addr_flag, brk_flag}, 32'h14);

    // R1: writes and flag pulses ignored under software reset
    @(negedge clk);
    soft_rst = 1'b1; wr_en = 1'b1; wr_data = 8'h5A; set_addr = 1'b1; set_brk = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; set_addr = 1'b0; set_brk = 1'b0;
    @(negedge clk);
    soft_rst = 1'b0;
    check(buf_empty === 1'b1 && addr_flag === 1'b0 && brk_flag === 1'b0, "R1",
          "inputs ignored in soft reset", {29'd0, buf_empty, addr_flag, brk_flag}, 32'h4);
    tick();
    tick();
    check(txd === 1'b1 && busy === 1'b0, "R1", "no frame after ignored write",
          {30'd0, txd, busy}, 32'h2);

    // Sweep every format with and without an address marking
    for (int cf = 0; cf < 128; cf++) begin
      for (int a = 0; a < 2; a++) begin
        run_one(cf, 8'hB6, a[0], 1'b0);
        run_one(cf, 8'h4D, a[0], 1'b0);
      end
    end
    // Breaks in every format
    for (int cf = 0; cf < 128; cf++) run_one(cf, 8'h00, 1'b0, 1'b1);

    // R2: format changes while running have no effect
    apply_cfg(0);
    @(negedge clk);
    cfg_par_en = 1'b1; cfg_len7 = 1'b1; cfg_two_stop = 1'b1; cfg_mode = 2'b10;
    write_byte(8'h93);
    expect_frame(0, 8'h93, 1'b0, 1'b0, ea, na);
    send_bits(ea, na, 0, "R2");
    idle_check("R2");

    // R8: set_addr in the same cycle as the take
    apply_cfg(2);
    write_byte(8'h21);
    @(negedge clk); baud_tick = 1'b1; set_addr = 1'b1;
    @(negedge clk); baud_tick = 1'b0; set_addr = 1'b0;
    expect_frame(2, 8'h21, 1'b0, 1'b0, ea, na);
    check(txd === ea[0] && addr_flag === 1'b1, "R8", "flag kept when set at take",
          {30'd0, txd, addr_flag}, {30'd0, ea[0], 1'b1});
    send_bits(ea, na, 1, "R8");
    idle_check("R8");
    write_byte(8'h21);
    expect_frame(2, 8'h21, 1'b1, 1'b0, eb, nb);
    send_bits(eb, nb, 0, "R8");
    idle_check("R8");
    check(addr_flag === 1'b0, "R8", "flag used by following frame", {31'd0, addr_flag}, 32'h0);

    // R10: write in the same cycle as the take, frames back to back
    apply_cfg(64);
    write_byte(8'hC3);
    @(negedge clk); baud_tick = 1'b1; wr_en = 1'b1; wr_data = 8'h3E;
    @(negedge clk); baud_tick = 1'b0; wr_en = 1'b0;
    check(buf_empty === 1'b0 && txd === 1'b0 && busy === 1'b1, "R10",
          "write kept during take", {29'd0, buf_empty, txd, busy}, 32'h1);
    expect_frame(64, 8'hC3, 1'b0, 1'b0, ea, na);
    expect_frame(64, 8'h3E, 1'b0, 1'b0, eb, nb);
    send_bits(ea, na, 1, "R10");
    send_bits(eb, nb, 0, "R10");
    check(buf_empty === 1'b1, "R10", "empty after second take", {31'd0, buf_empty}, 32'h1);
    idle_check("R11");

    // R1: soft reset in the middle of a frame
    apply_cfg(0);
    write_byte(8'hFF);
    tick(); tick(); tick();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0 && buf_empty === 1'b1, "R1",
          "soft reset mid frame", {29'd0, txd, busy, buf_empty}, 32'h5);
    soft_rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule